// File: doc/BRIEF.md
# Weighted Fair Queueing Tag Scheduler

This block orders packets from a small set of per-flow queues by virtual finish time. Each arriving packet names its flow and its length. The block stamps the packet with a start tag and a finish tag and stores the pair {length, finish tag} in that flow's tag FIFO. Packet payload is kept somewhere else. At every transmit opportunity the block offers the head-of-line entry with the smallest finish tag across all non-empty flows.

A packet that arrives at an empty flow starts at the current round number. A packet that arrives behind queued packets starts at the finish tag of the packet queued just before it in the same flow. The finish tag is the start tag plus the length divided by the flow's weight. The weight is a power of two, so the division is a right shift. The round number uses a self-clocked approximation: it takes the finish tag of the packet most recently sent. A flow with a larger weight therefore moves through virtual time more slowly and receives proportionally more bytes per round.

The arrival side is a valid-only stream with no back-pressure. An arrival to a full FIFO is discarded and flagged. The dequeue side is a valid/ready stream. `deq_valid` stays high while any flow holds a packet, and the offered entry moves on only in a cycle where `deq_ready` is also high.

Top module: `wfq_tag_sched`

## Requirements
- R1: After reset all flow FIFOs are empty, `deq_valid` is 0, `round_num` is 0 and `arr_drop` is 0.
- R2: A packet accepted for a flow whose FIFO is empty at the start of the cycle gets start tag S = `round_num` and finish tag F = S + scaled length.
- R3: A packet accepted for a flow whose FIFO is non-empty at the start of the cycle gets S equal to the finish tag of the last packet accepted for that flow, and F = S + scaled length.
- R4: The 2-bit weight code of flow i sits at `weight_sel[2i+1:2i]`. Codes 0, 1, 2 and 3 mean weights 1, 2, 4 and 8. The scaled length is `arr_len` shifted right by the code, so the result is floored. The code in force at the arrival cycle is the one used.
- R5: `deq_valid` is high exactly when some FIFO is non-empty. `deq_flow`, `deq_len` and `deq_finish` then show the head entry with the smallest finish tag. Each flow is served in its own arrival order. An entry is removed on a rising clock edge where `deq_valid` and `deq_ready` are both high.
- R6: After a transfer, `round_num` holds the transferred packet's finish tag from the next cycle on. `round_num` never decreases.
- R7: When several head entries share the smallest finish tag, the lowest flow index is offered.
- R8: An arrival to a flow whose FIFO holds DEPTH entries at the start of the cycle raises `arr_drop` in that same cycle. The packet is not stored, and that flow's queued contents are unchanged.
- R9: Arrivals are never back-pressured. An arrival and a transfer in the same cycle both take effect. Emptiness and fullness are judged from the occupancy at the start of the cycle.
- R10: `deq_ready` while `deq_valid` is low changes nothing: `round_num` and the queues keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arr_valid | input | 1 | A packet arrives this cycle |
| arr_flow | input | 2 | Flow index of the arriving packet |
| arr_len | input | 16 | Length of the arriving packet |
| arr_drop | output | 1 | The arrival this cycle is discarded because its FIFO is full |
| weight_sel | input | 8 | Weight code per flow, 2 bits each, flow 0 in the low bits |
| deq_ready | input | 1 | Downstream takes the offered packet |
| deq_valid | output | 1 | A packet is offered |
| deq_flow | output | 2 | Flow of the offered packet |
| deq_len | output | 16 | Length of the offered packet |
| deq_finish | output | 24 | Finish tag of the offered packet |
| round_num | output | 24 | Current round number |

## Verification
The hardest case to reach from the ports is an arrival and a transfer on the same flow in the same cycle, when that flow holds exactly one packet. The start tag must come from the packet that is leaving at that moment, not from the round number that is being updated. The bench builds a one-entry queue, then raises `arr_valid` and `deq_ready` together in one cycle. It then checks the new head's finish tag and the new round number. Exact ties are the other awkward case, along with a full FIFO. The tie is produced by choosing lengths and weights so that two flows land on equal finish tags. The full FIFO is produced by pushing DEPTH+1 packets into one flow with nothing draining it.

// File: rtl/wfq_pkg.sv
package wfq_pkg;
  // weight code: flow weight is 2**code
  typedef enum logic [1:0] {
    WGT_1 = 2'd0,
    WGT_2 = 2'd1,
    WGT_4 = 2'd2,
    WGT_8 = 2'd3
  } wgt_code_e;

  localparam int WGT_CODE_W = 2;
endpackage

// File: rtl/wfq_tag_fifo.sv
module wfq_tag_fifo #(
  parameter int WIDTH = 40,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  assign empty = (count == '0);
  assign full  = (count == CNT_MAX);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  // R8: the parent never writes into a full FIFO
  p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R5: entries only leave a FIFO that holds some
  p_no_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/wfq_min_select.sv
module wfq_min_select #(
  parameter int N    = 4,
  parameter int TAGW = 24,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    valid,
  input  logic [N*TAGW-1:0] tags,
  output logic            any,
  output logic [IW-1:0]   idx
);
  logic [TAGW-1:0] best;

  // strict less-than keeps the lowest index on a tie
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (valid[i] && (!any || tags[i*TAGW +: TAGW] < best)) begin
        any  = 1'b1;
        idx  = IW'(i);
        best = tags[i*TAGW +: TAGW];
      end
    end
  end

  // independent check of the chosen index against every candidate
  logic choice_ok;
  always_comb begin
    choice_ok = valid[idx];
    for (int i = 0; i < N; i++) begin
      if (valid[i]) begin
        if (tags[i*TAGW +: TAGW] < tags[idx*TAGW +: TAGW]) choice_ok = 1'b0;
        if (i < int'(idx) && tags[i*TAGW +: TAGW] == tags[idx*TAGW +: TAGW])
          choice_ok = 1'b0;
      end
    end
  end

  // R5 and R7: smallest finish tag, lowest index on a tie
  p_min_tie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> choice_ok);
  // R5: something is offered whenever a head exists
  p_any_when_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid != '0) |-> any);
endmodule

// File: rtl/wfq_tag_sched.sv
module wfq_tag_sched #(
  parameter int NFLOW = 4,
  parameter int DEPTH = 8,
  parameter int TAGW  = 24,
  parameter int LENW  = 16,
  localparam int FW   = (NFLOW > 1) ? $clog2(NFLOW) : 1,
  localparam int WW   = wfq_pkg::WGT_CODE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arr_valid,
  input  logic [FW-1:0]       arr_flow,
  input  logic [LENW-1:0]     arr_len,
  output logic                arr_drop,
  input  logic [NFLOW*WW-1:0] weight_sel,
  input  logic                deq_ready,
  output logic                deq_valid,
  output logic [FW-1:0]       deq_flow,
  output logic [LENW-1:0]     deq_len,
  output logic [TAGW-1:0]     deq_finish,
  output logic [TAGW-1:0]     round_num
);
  localparam int EW = LENW + TAGW;

  logic [NFLOW-1:0]      fifo_empty, fifo_full, push_v, pop_v;
  logic [EW-1:0]         head_e   [NFLOW];
  logic [NFLOW*TAGW-1:0] head_tags;
  logic [TAGW-1:0]       last_fin [NFLOW];
  logic [TAGW-1:0]       round_q;

  // ---- arrival tag computation ----
  wfq_pkg::wgt_code_e wcode;
  logic [LENW-1:0]    scaled_len;
  logic [TAGW-1:0]    start_tag, fin_tag;
  logic               accept, deq_fire;
  logic [FW-1:0]      sel;

  assign wcode      = wfq_pkg::wgt_code_e'(weight_sel[arr_flow*WW +: WW]);
  assign scaled_len = arr_len >> wcode;
  assign start_tag  = fifo_empty[arr_flow] ? round_q : last_fin[arr_flow];
  assign fin_tag    = start_tag + TAGW'(scaled_len);
  assign accept     = arr_valid && !fifo_full[arr_flow];
  assign arr_drop   = arr_valid && fifo_full[arr_flow];
  assign deq_fire   = deq_valid && deq_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NFLOW; i++) last_fin[i] <= '0;
      round_q <= '0;
    end else begin
      if (accept)   last_fin[arr_flow] <= fin_tag;
      if (deq_fire) round_q <= deq_finish;
    end
  end

  // ---- per-flow tag FIFOs ----
  for (genvar g = 0; g < NFLOW; g++) begin : g_flow
    assign push_v[g] = accept   && (arr_flow == FW'(g));
    assign pop_v[g]  = deq_fire && (sel == FW'(g));
    assign head_tags[g*TAGW +: TAGW] = head_e[g][TAGW-1:0];

    wfq_tag_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_v[g]),
      .push_data ({arr_len, fin_tag}),
      .pop       (pop_v[g]),
      .head      (head_e[g]),
      .empty     (fifo_empty[g]),
      .full      (fifo_full[g])
    );
  end

  // ---- smallest finish tag selection ----
  wfq_min_select #(.N(NFLOW), .TAGW(TAGW)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (~fifo_empty),
    .tags  (head_tags),
    .any   (deq_valid),
    .idx   (sel)
  );

  assign deq_flow   = sel;
  assign deq_finish = head_e[sel][TAGW-1:0];
  assign deq_len    = head_e[sel][EW-1:TAGW];
  assign round_num  = round_q;

  // R6: the round number is monotone
  p_round_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> round_q >= $past(round_q));
  // R6: round moves only through a transfer (covers R10)
  p_round_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !deq_fire |=> $stable(round_q));
  // R2: a new finish tag never lies behind the round
  p_tag_ahead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> fin_tag >= round_q);
  // R8: a drop never coincides with a write into that flow
  p_drop_no_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_drop |-> !push_v[arr_flow]);
endmodule

// File: tb/wfq_tag_sched_bench.sv
module wfq_tag_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arr_valid = 1'b0;
  logic [1:0]  arr_flow = '0;
  logic [15:0] arr_len = '0;
  logic        arr_drop;
  logic [7:0]  weight_sel = {2'd3, 2'd2, 2'd1, 2'd0};
  logic        deq_ready = 1'b0;
  logic        deq_valid;
  logic [1:0]  deq_flow;
  logic [15:0] deq_len;
  logic [23:0] deq_finish;
  logic [23:0] round_num;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  wfq_tag_sched u_wfq_tag_sched (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_flow(arr_flow),
    .arr_len(arr_len), .arr_drop(arr_drop), .weight_sel(weight_sel),
    .deq_ready(deq_ready), .deq_valid(deq_valid), .deq_flow(deq_flow),
    .deq_len(deq_len), .deq_finish(deq_finish), .round_num(round_num)
  );

  typedef struct packed {
    logic        deq;
    logic [1:0]  flow;
    logic [15:0] len;
    logic [23:0] fin;
  } step_t;

  // weights: flow0 x1, flow1 x2, flow2 x4, flow3 x8
  localparam int NSTEP = 14;
  localparam step_t TBL [NSTEP] = '{
    '{1'b0, 2'd0, 16'd8,  24'd0},
    '{1'b0, 2'd1, 16'd8,  24'd0},
    '{1'b0, 2'd2, 16'd16, 24'd0},
    '{1'b0, 2'd0, 16'd4,  24'd0},
    '{1'b0, 2'd3, 16'd16, 24'd0},
    '{1'b1, 2'd3, 16'd16, 24'd2},
    '{1'b1, 2'd1, 16'd8,  24'd4},   // tie with flow2 (R7)
    '{1'b1, 2'd2, 16'd16, 24'd4},
    '{1'b0, 2'd1, 16'd8,  24'd0},   // empty flow restarts at round (R2)
    '{1'b1, 2'd0, 16'd8,  24'd8},   // tie with flow1 (R7)
    '{1'b1, 2'd1, 16'd8,  24'd8},
    '{1'b0, 2'd3, 16'd9,  24'd0},   // 9>>3 floors to 1 (R4)
    '{1'b1, 2'd3, 16'd9,  24'd9},
    '{1'b1, 2'd0, 16'd4,  24'd12}   // queued behind 8 (R3)
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic arrive(input logic [1:0] f, input logic [15:0] len, input logic xdrop);
    @(negedge clk);
    arr_valid = 1'b1; arr_flow = f; arr_len = len;
    #1 chk("R8 drop flag", 32'(arr_drop), 32'(xdrop));
    @(negedge clk);
    arr_valid = 1'b0;
  endtask

  task automatic take(input logic [1:0] xf, input logic [15:0] xlen, input logic [23:0] xfin);
    @(negedge clk);
    #1;
    chk("R5 valid", 32'(deq_valid), 32'd1);
    chk("R5/R7 flow", 32'(deq_flow), 32'(xf));
    chk("R5 length", 32'(deq_len), 32'(xlen));
    chk("R2/R3/R4 finish", 32'(deq_finish), 32'(xfin));
    deq_ready = 1'b1;
    @(negedge clk);
    deq_ready = 1'b0;
    #1 chk("R6 round", 32'(round_num), 32'(xfin));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 deq_valid", 32'(deq_valid), 32'd0);
    chk("R1 round", 32'(round_num), 32'd0);
    chk("R1 drop", 32'(arr_drop), 32'd0);
    rst_n = 1'b1;

    for (int s = 0; s < NSTEP; s++) begin
      if (TBL[s].deq) take(TBL[s].flow, TBL[s].len, TBL[s].fin);
      else            arrive(TBL[s].flow, TBL[s].len, 1'b0);
    end

    // R10: ready with nothing offered
    @(negedge clk);
    #1 chk("R5 empty valid", 32'(deq_valid), 32'd0);
    deq_ready = 1'b1;
    @(negedge clk);
    deq_ready = 1'b0;
    #1 chk("R10 round held", 32'(round_num), 32'd12);
    chk("R10 still empty", 32'(deq_valid), 32'd0);

    // R8: fill flow2 (weight 4, len 4 -> +1 per packet) then overflow
    for (int k = 0; k < 8; k++) arrive(2'd2, 16'd4, 1'b0);
    arrive(2'd2, 16'd99, 1'b1);
    for (int k = 0; k < 8; k++) take(2'd2, 16'd4, 24'(13 + k));
    @(negedge clk);
    #1 chk("R8 dropped not stored", 32'(deq_valid), 32'd0);

    // R9: one-entry flow, arrival and transfer in the same cycle
    arrive(2'd0, 16'd2, 1'b0);          // F = 20 + 2
    @(negedge clk);
    #1 chk("R9 head before", 32'(deq_finish), 32'd22);
    arr_valid = 1'b1; arr_flow = 2'd0; arr_len = 16'd3;
    deq_ready = 1'b1;
    @(negedge clk);
    arr_valid = 1'b0; deq_ready = 1'b0;
    #1;
    chk("R9 round", 32'(round_num), 32'd22);
    chk("R9 flow", 32'(deq_flow), 32'd0);
    chk("R9 chained finish", 32'(deq_finish), 32'd25);
    take(2'd0, 16'd3, 24'd25);

    // R4: weight code taken at arrival time
    weight_sel[3:2] = 2'd3;
    arrive(2'd1, 16'd64, 1'b0);         // 25 + 8
    weight_sel[3:2] = 2'd0;
    arrive(2'd1, 16'd5, 1'b0);          // 33 + 5
    take(2'd1, 16'd64, 24'd33);
    take(2'd1, 16'd5, 24'd38);

    finish_run();
  end
endmodule